// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital control and counting core of a dual-slope voltage-to-count converter. It runs from a free-running tick. On each conversion it closes an input switch so that the signal current charges an external integrator for a fixed number of ticks. It then opens that switch and closes a reference switch that applies a current of opposite polarity. It counts ticks until a comparator reports that the integrator is back at its starting level. The count, less a fixed zero offset, becomes a signed reading that is range-checked against -99 and +999.

Conversions repeat at one of two periods. A decoded three-state rate control picks between them: fast, slow or hold. Hold keeps converting at the slow period but freezes the published reading. After hold has been applied once, the block stays at the slow period until the next reset, even if fast is requested again. A missing comparator event is caught by a reference-phase limit, and the result is then forced to positive overrange.

Top module: `dsc_seq`

## Requirements
- R1: While reset is asserted and directly after it, both switch outputs are low, `result_valid` is low, and `reading`, `ovr_pos` and `ovr_neg` are all zero.
- R2: The first conversion starts on the first tick after reset. After that a conversion starts every FAST_PERIOD ticks when the fast rate is in force and every SLOW_PERIOD ticks otherwise. The rate that applies to an interval is the one in force at the tick that started it. Clock cycles with `tick` low count toward no interval.
- R3: `sw_input` is high for exactly INT_TICKS ticks. In the cycle it falls, `sw_ref` rises. The two switches are never high together.
- R4: The count is the number of reference-phase ticks before the tick at which `comp_trip` is sampled high. `reading` is that count minus ZERO_OFS, as a signed RD_W-bit value. `result_valid` pulses for one cycle, in the second clock cycle after the edge that sampled the trip.
- R5: A reading above POS_LIMIT (999) sets `ovr_pos`. A reading below NEG_LIMIT (-99) sets `ovr_neg`. Readings from -99 to 999 inclusive set neither flag.
- R6: If `comp_trip` is not seen within MAX_REF reference-phase ticks, the reference phase ends. The result is then published with `ovr_pos` high, `ovr_neg` low and `reading` equal to MAX_REF minus ZERO_OFS.
- R7: While `sel_hold` is high, conversions still run at the slow period. However, `result_valid` never pulses, and `reading` and both flags keep their last published values.
- R8: Once `sel_hold` has been high in any cycle, every later interval uses the slow period, even if `sel_fast` is requested alone, until the next reset.
- R9: Hold takes priority over both rate flags. The fast rate applies only when `sel_fast` is high and `sel_slow` and `sel_hold` are both low. Any other combination selects the slow period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable from the free-running oscillator |
| sel_fast | input | 1 | Decoded rate control: fast |
| sel_slow | input | 1 | Decoded rate control: slow |
| sel_hold | input | 1 | Decoded rate control: hold |
| comp_trip | input | 1 | Comparator: integrator has returned to its start level |
| sw_input | output | 1 | Closes the input-current switch (integrate phase) |
| sw_ref | output | 1 | Closes the reference-current switch (de-integrate phase) |
| reading | output | RD_W | Published signed reading |
| ovr_pos | output | 1 | Published reading above the positive limit, or timeout |
| ovr_neg | output | 1 | Published reading below the negative limit |
| result_valid | output | 1 | One-cycle pulse when a new reading is published |

## Verification
The switches change on the clock edge that consumes a tick, so the bench samples them at the following falling edge. Start spacing and integrate length are measured in consumed ticks rather than cycles, so they remain correct when `tick` is gated. A reading is due in the second clock cycle after the edge that takes the trip or the timeout: one register to capture the count and one to publish it. The bench therefore arms a two-cycle countdown at the falling edge where it presents that tick. On every other cycle it checks that `result_valid` is low and that the reading and both flags have not moved.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INTEG = 2'd1,
        PH_REF   = 2'd2
    } phase_e;

endpackage

// File: rtl/dsc_rate.sv
module dsc_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_fast,
    input  logic sel_slow,
    input  logic sel_hold,
    output logic use_fast,
    output logic publish_en
);
    typedef struct packed {
        logic locked;
    } rate_t;

    rate_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.locked = r_q.locked | sel_hold;
        use_fast   = sel_fast & ~sel_slow & ~sel_hold & ~r_q.locked;
        publish_en = ~sel_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R8: hold forces the slow rate from the next cycle on
    a_r8_hold_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hold |=> !use_fast);
    a_r8_lock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.locked |=> r_q.locked);
endmodule

// File: rtl/dsc_pacer.sv
module dsc_pacer #(
    parameter int FAST_PERIOD = 2048,
    parameter int SLOW_PERIOD = 49152
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic use_fast,
    output logic start
);
    localparam int PW = $clog2(SLOW_PERIOD + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pace_t;

    pace_t p_d, p_q;

    always_comb begin
        p_d   = p_q;
        start = tick && (p_q.left == '0);
        if (tick) begin
            if (p_q.left == '0)
                p_d.left = use_fast ? PW'(FAST_PERIOD - 1) : PW'(SLOW_PERIOD - 1);
            else
                p_d.left = p_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R2: timing only advances on ticks
    a_r2_idle_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(p_q.left));
endmodule

// File: rtl/dsc_core.sv
module dsc_core
    import dsc_pkg::*;
#(
    parameter int INT_TICKS = 256,
    parameter int MAX_REF   = 1536,
    parameter int CW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          comp_trip,
    output logic          sw_input,
    output logic          sw_ref,
    output logic          done,
    output logic          timeout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
        logic          tmo;
        logic [CW-1:0] cap;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (start) begin
                    c_d.ph  = PH_INTEG;
                    c_d.cnt = '0;
                end
            end
            PH_INTEG: begin
                if (tick) begin
                    if (c_q.cnt == CW'(INT_TICKS - 1)) begin
                        c_d.ph  = PH_REF;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            PH_REF: begin
                if (tick) begin
                    if (comp_trip) begin
                        c_d.ph   = PH_IDLE;
                        c_d.done = 1'b1;
                        c_d.tmo  = 1'b0;
                        c_d.cap  = c_q.cnt;
                    end else if (c_q.cnt == CW'(MAX_REF - 1)) begin
                        c_d.ph   = PH_IDLE;
                        c_d.done = 1'b1;
                        c_d.tmo  = 1'b1;
                        c_d.cap  = CW'(MAX_REF);
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign sw_input = (c_q.ph == PH_INTEG);
    assign sw_ref   = (c_q.ph == PH_REF);
    assign done     = c_q.done;
    assign timeout  = c_q.tmo;
    assign count    = c_q.cap;

    // R3: switches exclusive, reference follows integrate directly
    a_r3_switch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_input && sw_ref));
    a_r3_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> sw_ref);
    // R2: a start never lands on a conversion in progress
    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (c_q.ph == PH_IDLE));
    // R4: a result only follows a reference phase
    a_r4_done_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sw_ref));
    // R6: reference count bounded
    a_r6_ref_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ref |-> (c_q.cnt < CW'(MAX_REF)));
endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
    parameter int CW        = 11,
    parameter int RD_W      = 12,
    parameter int ZERO_OFS  = 100,
    parameter int POS_LIMIT = 999,
    parameter int NEG_LIMIT = -99
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  logic                   timeout,
    input  logic [CW-1:0]          count,
    input  logic                   publish_en,
    output logic signed [RD_W-1:0] reading,
    output logic                   ovr_pos,
    output logic                   ovr_neg,
    output logic                   result_valid
);
    typedef struct packed {
        logic signed [RD_W-1:0] rd;
        logic                   pos;
        logic                   neg;
        logic                   vld;
    } res_t;

    res_t r_d, r_q;
    int   val;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        val     = int'(count) - ZERO_OFS;
        if (done && publish_en) begin
            r_d.rd  = RD_W'(val);
            r_d.pos = timeout || (val > POS_LIMIT);
            r_d.neg = !timeout && (val < NEG_LIMIT);
            r_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reading      = r_q.rd;
    assign ovr_pos      = r_q.pos;
    assign ovr_neg      = r_q.neg;
    assign result_valid = r_q.vld;

    // R5: flags never both set
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovr_pos && ovr_neg));
    // R7: publish only after a result outside hold
    a_r7_publish_gated: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(done) && $past(publish_en)));
    a_r7_reading_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(reading) && $stable(ovr_pos) && $stable(ovr_neg)));
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq #(
    parameter int FAST_PERIOD = 2048,
    parameter int SLOW_PERIOD = 49152,
    parameter int INT_TICKS   = 256,
    parameter int MAX_REF     = 1536,
    parameter int ZERO_OFS    = 100,
    parameter int POS_LIMIT   = 999,
    parameter int NEG_LIMIT   = -99,
    parameter int RD_W        = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   sel_fast,
    input  logic                   sel_slow,
    input  logic                   sel_hold,
    input  logic                   comp_trip,
    output logic                   sw_input,
    output logic                   sw_ref,
    output logic signed [RD_W-1:0] reading,
    output logic                   ovr_pos,
    output logic                   ovr_neg,
    output logic                   result_valid
);
    localparam int TOPC = (MAX_REF > INT_TICKS) ? MAX_REF : INT_TICKS;
    localparam int CW   = $clog2(TOPC + 1);

    logic          use_fast, publish_en, start, done, timeout;
    logic [CW-1:0] count;

    dsc_rate u_rate (
        .clk(clk), .rst_n(rst_n),
        .sel_fast(sel_fast), .sel_slow(sel_slow), .sel_hold(sel_hold),
        .use_fast(use_fast), .publish_en(publish_en)
    );

    dsc_pacer #(.FAST_PERIOD(FAST_PERIOD), .SLOW_PERIOD(SLOW_PERIOD)) u_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .use_fast(use_fast), .start(start)
    );

    dsc_core #(.INT_TICKS(INT_TICKS), .MAX_REF(MAX_REF), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .comp_trip(comp_trip), .sw_input(sw_input), .sw_ref(sw_ref),
        .done(done), .timeout(timeout), .count(count)
    );

    dsc_result #(.CW(CW), .RD_W(RD_W), .ZERO_OFS(ZERO_OFS),
                 .POS_LIMIT(POS_LIMIT), .NEG_LIMIT(NEG_LIMIT)) u_result (
        .clk(clk), .rst_n(rst_n), .done(done), .timeout(timeout),
        .count(count), .publish_en(publish_en), .reading(reading),
        .ovr_pos(ovr_pos), .ovr_neg(ovr_neg), .result_valid(result_valid)
    );

    // R1: outputs quiet straight after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sw_input && !sw_ref && !result_valid));
endmodule

// File: tb/dsc_seq_test.sv
module dsc_seq_test;
    localparam int FP = 1400, SP = 3000, IT = 100, MR = 1200, ZO = 100, RW = 12;
    localparam int NCONV = 12, WD = 100000;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, comp = 1'b0;
    logic sf, ss, sh;
    logic sw_in, sw_rf, rv, opos, oneg;
    logic signed [RW-1:0] rd;

    always #5 clk = ~clk;

    dsc_seq #(.FAST_PERIOD(FP), .SLOW_PERIOD(SP), .INT_TICKS(IT), .MAX_REF(MR),
              .ZERO_OFS(ZO), .POS_LIMIT(999), .NEG_LIMIT(-99), .RD_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_fast(sf), .sel_slow(ss),
        .sel_hold(sh), .comp_trip(comp), .sw_input(sw_in), .sw_ref(sw_rf),
        .reading(rd), .ovr_pos(opos), .ovr_neg(oneg), .result_valid(rv)
    );

    int kv[NCONV] = '{100, 1099, 1100, 1, 0, 5000, 500, 300, 700, 250, 50, 75};
    bit mf[NCONV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1};
    bit ms[NCONV] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    bit mh[NCONV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
    int td[NCONV] = '{1, 1, 1, 1, 1, 1, 2, 1, 1, 1, 1, 1};

    int tests = 0, fails = 0;
    int nstart = 0, last_t = 0, tick_total = 0, ref_seen = 0, int_ticks = 0;
    int kcur = 0, cd = -1, exp_rd = 0, pub_rd = 0, matured = 0, cyc = 0;
    int cur_div = 1, per_exp = 0, tail = 0;
    bit exp_pos, exp_neg, pub_pos = 0, pub_neg = 0, prev_in = 0, held = 0;
    string exp_req, gap_req;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic sched(input int cnt, input bit tmo);
        cd      = 2;
        exp_rd  = tmo ? (MR - ZO) : (cnt - ZO);
        exp_pos = tmo || (exp_rd > 999);
        exp_neg = !tmo && (exp_rd < -99);
        exp_req = tmo ? "R6" : ((exp_pos || exp_neg) ? "R5" : "R4");
    endtask

    task automatic step();
        // result pipeline
        if (cd > 0) cd--;
        if (cd == 0) begin
            cd = -1;
            matured++;
            if (!sh) begin
                chk(rv == 1'b1, {exp_req, " valid pulse"}, int'(rv), 1);
                pub_rd = exp_rd; pub_pos = exp_pos; pub_neg = exp_neg;
            end else begin
                chk(rv == 1'b0, "R7 no pulse in hold", int'(rv), 0);
            end
        end else begin
            chk(rv == 1'b0, "R4 no stray pulse", int'(rv), 0);
        end
        chk(int'(rd) == pub_rd, sh ? "R7 reading" : "R4 reading", int'(rd), pub_rd);
        chk(opos == pub_pos, sh ? "R7 ovr_pos" : "R5 ovr_pos", int'(opos), int'(pub_pos));
        chk(oneg == pub_neg, sh ? "R7 ovr_neg" : "R5 ovr_neg", int'(oneg), int'(pub_neg));
        chk(!(sw_in && sw_rf), "R3 exclusive", int'(sw_in && sw_rf), 0);
        // conversion start
        if (!prev_in && sw_in && nstart < NCONV) begin
            if (nstart == 0) chk(tick_total == 1, "R2 first start", tick_total, 1);
            else chk(tick_total - last_t == per_exp, gap_req, tick_total - last_t, per_exp);
            per_exp = (sf && !ss && !sh && !held) ? FP : SP;
            gap_req = (sf && !ss && !sh && held) ? "R8 sticky slow" :
                      ((sf && (ss || sh)) ? "R9 priority" : "R2 period");
            last_t    = tick_total;
            kcur      = kv[nstart];
            sf        = mf[nstart];
            ss        = ms[nstart];
            sh        = mh[nstart];
            if (mh[nstart]) held = 1'b1;
            cur_div   = td[nstart];
            int_ticks = 0;
            nstart++;
        end
        if (prev_in && !sw_in) begin
            chk(int_ticks == IT, "R3 integrate length", int_ticks, IT);
            chk(sw_rf == 1'b1, "R3 reference follows", int'(sw_rf), 1);
        end
        prev_in = sw_in;
        // drive for the next edge
        tick = ((cyc % cur_div) == 0);
        if (sw_rf) begin
            comp = (ref_seen >= kcur);
            if (tick) begin
                if (comp) sched(ref_seen, 1'b0);
                else if (ref_seen == MR - 1) sched(0, 1'b1);
                ref_seen++;
            end
        end else begin
            comp = 1'b0;
            ref_seen = 0;
        end
        if (sw_in && tick) int_ticks++;
        if (tick) tick_total++;
    endtask

    initial begin
        sf = mf[0]; ss = ms[0]; sh = mh[0];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!sw_in && !sw_rf, "R1 switches", int'(sw_in) + int'(sw_rf), 0);
        chk(rv == 1'b0, "R1 valid", int'(rv), 0);
        chk(rd == '0 && !opos && !oneg, "R1 reading", int'(rd), 0);
        rst_n = 1'b1;
        while (cyc < WD && tail < 20) begin
            @(negedge clk);
            cyc++;
            step();
            if (matured == NCONV) tail++;
        end
        if (cyc >= WD) chk(1'b0, "watchdog", cyc, WD);
        chk(nstart == NCONV, "R2 start count", nstart, NCONV);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule